// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-allocate cache for a word-wide processor port. The main store is direct mapped, 1 KB in total, with 32-byte lines. A small fully associative side buffer holds lines that the main store has recently evicted, so two lines that compete for the same main slot do not have to go back to memory each time.

A read that hits the main store is answered in the cycle it is presented. A read that misses there checks the side buffer in a second cycle. If the side buffer hits, the wanted line and the displaced main line trade places and the word is returned in that same cycle. Only a miss in both structures fetches a whole line from the lower level. It fetches the line in one read transfer, and the displaced main line then drops into the side buffer. Writes are write-through with no allocation. A write updates whichever copy holds the word, and every write is forwarded to the lower level.

The processor holds `cpu_req` and its address and data steady until `cpu_ready` is high for one cycle. The lower level answers a held `mem_req` with a single `mem_ready` cycle.

Top module: `vc_cache`

## Requirements
- R1: After reset every line in both structures is invalid, `cpu_ready` and `mem_req` are low, and the first read of any address misses.
- R2: The address splits as tag = bits 31:10, main index = bits 9:5 and word within line = bits 4:2. Two addresses that share the index but differ in tag compete for one main slot.
- R3: A read that hits the main store raises `cpu_ready` in the first cycle of the request with the addressed word. `cpu_ready` is never high without `cpu_req`.
- R4: A read that misses both structures issues one line read with `mem_we`=0 and `mem_addr` equal to the address with bits 4:0 cleared. It completes in the cycle `mem_ready` is high, returning word bits 4:2 of `mem_rdata`, where word k is bits 32k+31:32k.
- R5: When a refill replaces a valid main line, that line is moved into the side buffer and stays readable without a memory access.
- R6: A read that misses the main store but hits the side buffer completes in the second cycle with no memory request. The two lines swap, so the requested line then hits the main store and the displaced line hits the side buffer.
- R7: A line entering the side buffer after a refill takes the lowest-numbered invalid entry of the 4. If all 4 are valid, it takes the entry at a FIFO pointer, which then advances modulo 4. Swaps do not move the pointer.
- R8: Every write issues one memory write with `mem_we`=1, `mem_addr`=`cpu_addr` and `mem_wdata`=`cpu_wdata`. It completes in the cycle `mem_ready` is high, whether or not it hit.
- R9: A write that hits either structure updates that copy, so later reads return the new word. A write that misses allocates nothing, so a later read of that line still misses.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | Request complete this cycle |
| mem_req | output | 1 | Lower-level request |
| mem_we | output | 1 | Lower-level write |
| mem_addr | output | 32 | Line address on reads, byte address on writes |
| mem_wdata | output | 32 | Write word to the lower level |
| mem_rdata | input | 256 | Refill line from the lower level |
| mem_ready | input | 1 | Lower-level completion, one cycle |

## Verification
The hardest state to reach from the ports is a full side buffer whose FIFO pointer has already wrapped while swaps have reshuffled which entry holds which line. Only then do the FIFO replacement and the swap-preserves-slot rule interact. The stimulus first drives a chain of reads to six distinct tags on one index, which fills the buffer and forces overflow. It then interleaves swaps and further misses on that index. A long random phase follows on a deliberately small set of tags and indices, so conflicts, swaps and FIFO overflow recur many times, each compared against a behavioural model of both structures.

// File: rtl/vc_cache.sv
module vc_cache #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 5,
  parameter int WORD_W = 32,
  parameter int VB_N   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [WORD_W-1:0]               cpu_wdata,
  output logic [WORD_W-1:0]               cpu_rdata,
  output logic                            cpu_ready,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [WORD_W-1:0]               mem_wdata,
  input  logic [8*(1<<OFF_W)-1:0]         mem_rdata,
  input  logic                            mem_ready
);
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = 8 * (1 << OFF_W);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int VP_W   = $clog2(VB_N);

  typedef enum logic [1:0] {S_IDLE, S_VCHK, S_MRD, S_MWR} st_t;
  st_t st;

  logic [LINE_W-1:0] m_data [SETS];
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [SETS-1:0]   m_val;
  logic [LINE_W-1:0] v_data [VB_N];
  logic [BLK_W-1:0]  v_blk  [VB_N];
  logic [VB_N-1:0]   v_val;
  logic [VP_W-1:0]   v_ptr;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [BLK_W-1:0]  req_blk;
  logic [WSEL_W-1:0] req_w;
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_blk = cpu_addr[ADDR_W-1:OFF_W];
  assign req_w   = cpu_addr[OFF_W-1:BSEL_W];

  logic m_hit;
  assign m_hit = m_val[req_idx] && (m_tag[req_idx] == req_tag);

  logic [VB_N-1:0] v_match;
  genvar g;
  generate
    for (g = 0; g < VB_N; g++) begin : g_vcmp
      assign v_match[g] = v_val[g] && (v_blk[g] == req_blk);
    end
  endgenerate

  logic            v_hit, any_free;
  logic [VP_W-1:0] v_sel, v_free, v_alloc;
  assign v_hit    = |v_match;
  assign any_free = ~&v_val;
  always_comb begin
    v_sel  = '0;
    v_free = '0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (v_match[i]) v_sel = VP_W'(i);
      if (!v_val[i])  v_free = VP_W'(i);
    end
  end
  assign v_alloc = any_free ? v_free : v_ptr;

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] ln, input logic [WSEL_W-1:0] w);
    return ln[w*WORD_W +: WORD_W];
  endfunction

  assign cpu_ready = (st == S_IDLE && cpu_req && !cpu_we && m_hit) ||
                     (st == S_VCHK && v_hit) ||
                     ((st == S_MRD || st == S_MWR) && mem_ready);
  assign cpu_rdata = (st == S_VCHK) ? pick(v_data[v_sel], req_w) :
                     (st == S_MRD)  ? pick(mem_rdata, req_w) :
                                      pick(m_data[req_idx], req_w);

  assign mem_req   = (st == S_MRD) || (st == S_MWR);
  assign mem_we    = (st == S_MWR);
  assign mem_addr  = (st == S_MWR) ? cpu_addr : {req_blk, {OFF_W{1'b0}}};
  assign mem_wdata = cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      m_val <= '0;
      v_val <= '0;
      v_ptr <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          if (cpu_we) begin
            if (m_hit)      m_data[req_idx][req_w*WORD_W +: WORD_W] <= cpu_wdata;
            else if (v_hit) v_data[v_sel][req_w*WORD_W +: WORD_W]   <= cpu_wdata;
            st <= S_MWR;
          end else if (!m_hit) begin
            st <= S_VCHK;
          end
        end
        S_VCHK: begin
          if (v_hit) begin
            m_data[req_idx] <= v_data[v_sel];
            m_tag[req_idx]  <= req_tag;
            m_val[req_idx]  <= 1'b1;
            v_data[v_sel]   <= m_data[req_idx];
            v_blk[v_sel]    <= {m_tag[req_idx], req_idx};
            v_val[v_sel]    <= m_val[req_idx];
            st <= S_IDLE;
          end else begin
            st <= S_MRD;
          end
        end
        S_MRD: if (mem_ready) begin
          if (m_val[req_idx]) begin
            v_data[v_alloc] <= m_data[req_idx];
            v_blk[v_alloc]  <= {m_tag[req_idx], req_idx};
            v_val[v_alloc]  <= 1'b1;
            if (!any_free)
              v_ptr <= (v_ptr == VP_W'(VB_N - 1)) ? '0 : v_ptr + 1'b1;
          end
          m_data[req_idx] <= mem_rdata;
          m_tag[req_idx]  <= req_tag;
          m_val[req_idx]  <= 1'b1;
          st <= S_IDLE;
        end
        S_MWR: if (mem_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int WORD_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req,
  input logic                    cpu_we,
  input logic                    cpu_ready,
  input logic                    mem_req,
  input logic                    mem_we,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    mem_ready
);
  assert_ready_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  assert_line_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[OFF_W-1:0] == '0));

  assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_ready && mem_req && mem_we));

  assert_read_no_mem_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> !mem_we);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
endmodule

bind vc_cache vc_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready));

// File: tb/test_vc_cache.sv
`timescale 1ns/100ps
module test_vc_cache;
  localparam int LAT = 2;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [31:0] cpu_rdata;
  logic cpu_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [255:0] mem_rdata = '0;
  logic mem_ready = 0;

  vc_cache i_vc_cache (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] mem [logic [31:0]];
  int n_rd = 0, n_wr = 0;
  logic [31:0] last_raddr, last_waddr, last_wdata;

  int mtag [32];
  bit mv [32];
  int vblk [4];
  bit vv [4];
  int vp = 0;

  function automatic logic [31:0] memrd(logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    if (mem.exists(k)) return mem[k];
    return (k * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // lower-level model
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 0;
        cnt = 0;
      end else if (mem_req) begin
        if (cnt == LAT) begin
          if (mem_we) begin
            mem[{mem_addr[31:2], 2'b00}] = mem_wdata;
            n_wr++; last_waddr = mem_addr; last_wdata = mem_wdata;
          end else begin
            for (int w = 0; w < 8; w++) mem_rdata[w*32 +: 32] = memrd(mem_addr + 32'(4*w));
            n_rd++; last_raddr = mem_addr;
          end
          mem_ready = 1;
        end else cnt++;
      end
    end
  end

  // model: returns 0 main hit, 1 victim hit, 2 miss
  function automatic int model_read(logic [31:0] a);
    int blk = int'(a >> 5);
    int idx = blk & 31;
    int tg  = int'(a >> 10);
    if (mv[idx] && mtag[idx] == tg) return 0;
    for (int i = 0; i < 4; i++)
      if (vv[i] && vblk[i] == blk) begin
        vblk[i] = (mtag[idx] << 5) | idx;
        vv[i] = mv[idx];
        mtag[idx] = tg; mv[idx] = 1;
        return 1;
      end
    if (mv[idx]) begin
      int e = -1;
      for (int i = 3; i >= 0; i--) if (!vv[i]) e = i;
      if (e < 0) begin e = vp; vp = (vp + 1) % 4; end
      vblk[e] = (mtag[idx] << 5) | idx; vv[e] = 1;
    end
    mtag[idx] = tg; mv[idx] = 1;
    return 2;
  endfunction

  task automatic xact(bit we, logic [31:0] a, logic [31:0] d, output int lat, output logic [31:0] rd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    lat = 0;
    #1;
    while (!cpu_ready && lat < 100) begin
      @(negedge clk); #1; lat++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic do_rd(logic [31:0] a, string req);
    int lat, kind, r0;
    logic [31:0] rd, exp;
    int elat [3] = '{0, 1, 2 + LAT};
    exp = memrd(a);
    r0 = n_rd;
    kind = model_read(a);
    xact(0, a, 0, lat, rd);
    chk(lat == elat[kind], req, $sformatf("read latency kind=%0d", kind), lat, elat[kind]);
    chk(rd == exp, req, "read data", rd, exp);
    chk(n_rd - r0 == (kind == 2 ? 1 : 0), req, "memory line reads", n_rd - r0, kind == 2 ? 1 : 0);
    if (kind == 2) chk(last_raddr == {a[31:5], 5'b0}, "R4", "line address", last_raddr, {a[31:5], 5'b0});
  endtask

  task automatic do_wr(logic [31:0] a, logic [31:0] d, string req);
    int lat, w0;
    logic [31:0] rd;
    w0 = n_wr;
    xact(1, a, d, lat, rd);
    chk(lat == 1 + LAT, req, "write latency", lat, 1 + LAT);
    chk(n_wr - w0 == 1, "R8", "memory writes", n_wr - w0, 1);
    chk(last_waddr == a && last_wdata == d, "R8", "write address/data", last_waddr, a);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] A, B;
    for (int i = 0; i < 32; i++) begin mv[i] = 0; mtag[i] = 0; end
    for (int i = 0; i < 4; i++) begin vv[i] = 0; vblk[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_ready && !mem_req, "R1", "outputs idle in reset", {cpu_ready, mem_req}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!cpu_ready && !mem_req, "R1", "outputs idle after reset", {cpu_ready, mem_req}, 0);

    A = 32'h0000_1040;
    B = A + 32'h400;
    do_rd(A, "R1");
    do_rd(A + 4, "R3");
    do_rd(A + 28, "R3");
    do_rd(B + 8, "R2");
    do_rd(A + 12, "R5");
    do_rd(B, "R6");
    do_rd(B + 4, "R6");
    do_rd(A, "R6");
    for (int t = 2; t < 8; t++) do_rd(A + 32'(t) * 32'h400, "R7");
    do_rd(A, "R7");
    do_rd(B, "R7");
    do_rd(A + 32'h1400, "R7");
    do_rd(A + 32'h0C00, "R7");
    do_wr(A + 32'h0C00 + 8, 32'hCAFE_0001, "R9");
    do_rd(A + 32'h0C00 + 8, "R9");
    do_wr(A + 32'h1C00 + 4, 32'hCAFE_0002, "R9");
    do_rd(A + 32'h1C00 + 4, "R9");
    do_wr(32'h0008_0064, 32'hCAFE_0003, "R8");
    do_rd(32'h0008_0064, "R9");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      a = ({29'(0), 3'($urandom)} << 10) | ({30'(0), 2'($urandom)} << 5) | ({29'(0), 3'($urandom)} << 2);
      if ($urandom % 3 == 0) do_wr(a, $urandom, "R9");
      else do_rd(a, "R7");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule